// File: doc/BRIEF.md
# Chip-Select Timing Sequencer

This block frames each serial transfer with an active-low chip select and spaces that select from the serial clock. A start request asserts one of two selects. The shift engine is allowed to clock only after a programmable lead-in time. Once the engine reports its final unit, the select is held for a programmable tail and then released. A programmable idle gap must then pass before the next request can take effect. A hold option keeps the select low between back-to-back transfers.

The four delays share one timing word. Each is a 4-bit count of input clock cycles, so all four are set with one write. The block also tells the clock generator which divider to use. Transfers on the second select may use their own 16-bit divider when its enable is set.

Top module: `cs_timing_seq`

## Requirements
- R1: After reset both select lines are high (deasserted), the clock permission is low, and the timing fields hold lead 6, release 4, hold 6 and gap 6.
- R2: A timing write loads lead from bits [3:0], release from [11:8], hold from [19:16] and gap from [27:24]. All other bits of the word are ignored.
- R3: A start sampled in idle drives the chosen select low after that edge. The clock permission rises `lead` cycles later and is never high while no select is low.
- R4: An end-of-data sampled while clocking drops the permission after that edge. The select is released max(release, hold) cycles later.
- R5: After release, starts sampled on the next `gap` edges are ignored. A start on the edge after that is accepted.
- R6: `cs_sel_i` (0 or 1) is latched on an accepted start. `cs_no[i]` is low only for the latched select, and at most one select is low at any time.
- R7: `div_o` equals `alt_div_i` while select 1 is low and `alt_div_en_i` is 1. It equals `main_div_i` while select 0 is low, or while select 1 is low with the enable clear.
- R8: With `hold_cs_i` high at end-of-data, the select stays low and the permission stays low. A new start then enables clocking on the next edge with no lead delay. Clearing `hold_cs_i` starts the release.
- R9: A field value of 0 adds no cycles. The permission rises on the same edge as the select falls, and the release happens on the edge that samples end-of-data.
- R10: A start while a transfer is active, and an end-of-data while not clocking, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all delays count its cycles |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tm_we_i | input | 1 | Load timing word |
| tm_wdata_i | input | 32 | Timing word |
| start_i | input | 1 | Transfer start request |
| last_i | input | 1 | End-of-data from the shift engine |
| hold_cs_i | input | 1 | Keep select asserted after end-of-data |
| cs_sel_i | input | 1 | Select index for the next transfer |
| main_div_i | input | 16 | Main clock divider |
| alt_div_i | input | 16 | Divider for select 1 |
| alt_div_en_i | input | 1 | Use alt_div_i for select 1 |
| cs_no | output | 2 | Active-low chip selects |
| sclk_en_o | output | 1 | Permission for the serial clock to run |
| div_o | output | 16 | Divider chosen for the current select |

## Verification
The vector table runs full transfers with timing words of several kinds: all-zero fields, a release longer than the hold, a hold longer than the release, the maximum field value, and a word with junk in its reserved bits. These cases separate the lead count from the release count, show whether the larger of release and hold wins, and catch swapped or misplaced fields. The rows vary the select and the alternate enable, which tells the main and alternate dividers apart. Directed runs probe the gap boundary one edge before and at acceptance, ignored starts and end-of-data pulses, and the held-select path.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  localparam int DLY_W   = 4;
  localparam int NUM_FLD = 4;
  localparam int FLD_STRIDE = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_RUN, ST_TRAIL, ST_KEEP, ST_GAP
  } seq_state_e;

  typedef struct packed {
    logic [DLY_W-1:0] gap;
    logic [DLY_W-1:0] hold;
    logic [DLY_W-1:0] rel;
    logic [DLY_W-1:0] lead;
  } tm_t;

  // index 0 lead, 1 release, 2 hold, 3 gap
  function automatic logic [DLY_W-1:0] tm_dflt(int idx);
    return (idx == 1) ? DLY_W'(4) : DLY_W'(6);
  endfunction

  function automatic logic [DLY_W-1:0] dly_max(logic [DLY_W-1:0] a, logic [DLY_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cs_tm_reg.sv
module cs_tm_reg
  import cs_seq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output tm_t               tm_o
);
  logic [DLY_W-1:0] fld_q [NUM_FLD];

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   fld_q[g] <= tm_dflt(g);
      else if (we_i) fld_q[g] <= wdata_i[g*FLD_STRIDE +: DLY_W];
    end
  end

  logic unused_rsvd;
  assign unused_rsvd = ^{wdata_i[31:28], wdata_i[23:20], wdata_i[15:12], wdata_i[7:4]};

  assign tm_o = '{gap: fld_q[3], hold: fld_q[2], rel: fld_q[1], lead: fld_q[0]};
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
  import cs_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  tm_t  tm_i,
  input  logic start_i,
  input  logic last_i,
  input  logic hold_cs_i,
  input  logic cs_sel_i,
  output logic cs_act_o,
  output logic run_o,
  output logic sel_o
);
  seq_state_e st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic sel_q, sel_d;
  logic [DLY_W-1:0] rel_len;

  assign rel_len = dly_max(tm_i.rel, tm_i.hold);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sel_d = sel_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        sel_d = cs_sel_i;
        cnt_d = tm_i.lead;
        st_d  = (tm_i.lead == '0) ? ST_RUN : ST_LEAD;
      end
      ST_LEAD: begin
        if (cnt_q == DLY_W'(1)) st_d = ST_RUN;
        else cnt_d = cnt_q - 1'b1;
      end
      ST_RUN: if (last_i) begin
        if (hold_cs_i) st_d = ST_KEEP;
        else if (rel_len != '0) begin st_d = ST_TRAIL; cnt_d = rel_len; end
        else begin
          cnt_d = tm_i.gap;
          st_d  = (tm_i.gap == '0) ? ST_IDLE : ST_GAP;
        end
      end
      ST_KEEP: begin
        if (start_i) st_d = ST_RUN;
        else if (!hold_cs_i) begin
          if (rel_len != '0) begin st_d = ST_TRAIL; cnt_d = rel_len; end
          else begin
            cnt_d = tm_i.gap;
            st_d  = (tm_i.gap == '0) ? ST_IDLE : ST_GAP;
          end
        end
      end
      ST_TRAIL: begin
        if (cnt_q == DLY_W'(1)) begin
          cnt_d = tm_i.gap;
          st_d  = (tm_i.gap == '0) ? ST_IDLE : ST_GAP;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_GAP: begin
        if (cnt_q == DLY_W'(1)) st_d = ST_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  assign cs_act_o = (st_q == ST_LEAD) || (st_q == ST_RUN) ||
                    (st_q == ST_TRAIL) || (st_q == ST_KEEP);
  assign run_o    = (st_q == ST_RUN);
  assign sel_o    = sel_q;
endmodule

// File: rtl/cs_drive.sv
module cs_drive #(
  parameter int NUM_CS = 2,
  parameter int DIV_W  = 16,
  parameter int ALT_CS = 1
) (
  input  logic             cs_act_i,
  input  logic             sel_i,
  input  logic [DIV_W-1:0] main_div_i,
  input  logic [DIV_W-1:0] alt_div_i,
  input  logic             alt_div_en_i,
  output logic [NUM_CS-1:0] cs_no,
  output logic [DIV_W-1:0] div_o
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = !(cs_act_i && (32'(sel_i) == g));
  end

  assign div_o = (32'(sel_i) == ALT_CS && alt_div_en_i) ? alt_div_i : main_div_i;
endmodule

// File: rtl/cs_timing_seq.sv
module cs_timing_seq
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int DIV_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tm_we_i,
  input  logic [WORD_W-1:0] tm_wdata_i,
  input  logic              start_i,
  input  logic              last_i,
  input  logic              hold_cs_i,
  input  logic              cs_sel_i,
  input  logic [DIV_W-1:0]  main_div_i,
  input  logic [DIV_W-1:0]  alt_div_i,
  input  logic              alt_div_en_i,
  output logic [NUM_CS-1:0] cs_no,
  output logic              sclk_en_o,
  output logic [DIV_W-1:0]  div_o
);
  tm_t  tm;
  logic cs_act, sel;

  cs_tm_reg #(.WORD_W(WORD_W)) u_tm (
    .clk_i, .rst_ni, .we_i(tm_we_i), .wdata_i(tm_wdata_i), .tm_o(tm)
  );

  cs_seq_fsm u_fsm (
    .clk_i, .rst_ni, .tm_i(tm), .start_i, .last_i, .hold_cs_i, .cs_sel_i,
    .cs_act_o(cs_act), .run_o(sclk_en_o), .sel_o(sel)
  );

  cs_drive #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) u_drv (
    .cs_act_i(cs_act), .sel_i(sel), .main_div_i, .alt_div_i, .alt_div_en_i,
    .cs_no, .div_o
  );
endmodule

// File: rtl/cs_timing_seq_chk.sv
module cs_timing_seq_chk
  import cs_seq_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       cs_no,
  input logic             sclk_en_o,
  input logic             last_i,
  input logic [DIV_W-1:0] div_o,
  input logic [DIV_W-1:0] main_div_i,
  input logic [DIV_W-1:0] alt_div_i,
  input logic             alt_div_en_i,
  input tm_t              tm
);
  p_cs_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  p_clk_needs_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_en_o |-> !(&cs_no));
  p_clk_off_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_en_o && last_i) |=> !sclk_en_o);
  p_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(&cs_no) && tm.gap != '0) |=> (&cs_no));
  p_div_main_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no[0] |-> (div_o == main_div_i));
  p_div_alt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no[1] && alt_div_en_i) |-> (div_o == alt_div_i));
endmodule

bind cs_timing_seq cs_timing_seq_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i, .rst_ni, .cs_no, .sclk_en_o, .last_i, .div_o,
  .main_div_i, .alt_div_i, .alt_div_en_i, .tm(tm)
);

// File: tb/tb_cs_timing_seq.sv
module tb_cs_timing_seq;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tm_we = 1'b0;
  logic [31:0] tm_wdata = '0;
  logic start = 1'b0, last = 1'b0, hold_cs = 1'b0, cs_sel = 1'b0;
  logic [15:0] main_div = 16'h1234, alt_div = 16'hBEEF;
  logic alt_en = 1'b0;
  logic [1:0] cs_no;
  logic sclk_en;
  logic [15:0] div;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cs_timing_seq dut (
    .clk_i(clk), .rst_ni, .tm_we_i(tm_we), .tm_wdata_i(tm_wdata),
    .start_i(start), .last_i(last), .hold_cs_i(hold_cs), .cs_sel_i(cs_sel),
    .main_div_i(main_div), .alt_div_i(alt_div), .alt_div_en_i(alt_en),
    .cs_no, .sclk_en_o(sclk_en), .div_o(div)
  );

  typedef struct packed {
    logic [31:0] word;
    logic        sel;
    logic        alt;
    logic [4:0]  on;
    logic [4:0]  rel;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{32'h0000_0000, 1'b0, 1'b0, 5'd0,  5'd0},
    '{32'h0301_0502, 1'b1, 1'b1, 5'd2,  5'd5},
    '{32'h0207_010F, 1'b0, 1'b1, 5'd15, 5'd7},
    '{32'h0F0F_0F01, 1'b1, 1'b0, 5'd1,  5'd15},
    '{32'hF0A0_B0C3, 1'b1, 1'b1, 5'd3,  5'd0}
  };

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_tm(logic [31:0] w);
    tm_wdata = w; tm_we = 1'b1;
    @(negedge clk);
    tm_we = 1'b0;
  endtask

  // start, measure lead, check div, end, measure release
  task automatic xfer(logic sel, logic alt, int exp_on, int exp_rel, string tag);
    int n;
    alt_en = alt;
    cs_sel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cs_no == ~(2'b01 << sel), {tag, " R6 select"}, cs_no, ~(2'b01 << sel));
    n = 0;
    for (int i = 0; i < 40 && !sclk_en; i++) begin n++; @(negedge clk); end
    check(n == exp_on, {tag, " R3 lead"}, n, exp_on);
    check(div == ((sel && alt) ? alt_div : main_div), {tag, " R7 divider"},
          div, (sel && alt) ? alt_div : main_div);
    repeat (2) @(negedge clk);
    last = 1'b1;
    @(negedge clk);
    last = 1'b0;
    check(!sclk_en, {tag, " R4 clock off"}, sclk_en, 0);
    n = 0;
    for (int i = 0; i < 40 && !(&cs_no); i++) begin n++; @(negedge clk); end
    check(n == exp_rel, {tag, " R4 release"}, n, exp_rel);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    check(cs_no == 2'b11, "R1 selects high", cs_no, 2'b11);
    check(!sclk_en, "R1 clock permission low", sclk_en, 0);

    // vector table: R2, R3, R4, R6, R7, R9
    foreach (VEC[k]) begin
      write_tm(VEC[k].word);
      xfer(VEC[k].sel, VEC[k].alt, int'(VEC[k].on), int'(VEC[k].rel), $sformatf("vec%0d", k));
      repeat (20) @(negedge clk);
    end

    // defaults after reset: R1 lead 6, release max(4,6)=6
    do_reset();
    xfer(1'b0, 1'b0, 6, 6, "dflt R1");
    // gap boundary R5: release seen, gap 6
    repeat (5) @(negedge clk);
    cs_sel = 1'b1; start = 1'b1;
    @(negedge clk);
    check(cs_no == 2'b11, "R5 start inside gap ignored", cs_no, 2'b11);
    @(negedge clk);
    start = 1'b0;
    check(cs_no == 2'b01, "R5 start after gap accepted", cs_no, 2'b01);
    for (int i = 0; i < 40 && !sclk_en; i++) @(negedge clk);
    // R10: start while active ignored
    cs_sel = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(cs_no == 2'b01 && sclk_en, "R10 start while busy", {cs_no, sclk_en}, 3'b011);
    last = 1'b1;
    @(negedge clk);
    last = 1'b0;
    repeat (20) @(negedge clk);
    // R10: end-of-data in idle ignored
    last = 1'b1;
    @(negedge clk);
    last = 1'b0;
    @(negedge clk);
    check(cs_no == 2'b11 && !sclk_en, "R10 last in idle", {cs_no, sclk_en}, 3'b110);

    // R8: held select
    cs_sel = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40 && !sclk_en; i++) @(negedge clk);
    hold_cs = 1'b1; last = 1'b1;
    @(negedge clk);
    last = 1'b0;
    repeat (10) @(negedge clk);
    check(cs_no == 2'b01 && !sclk_en, "R8 select kept", {cs_no, sclk_en}, 3'b010);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(sclk_en, "R8 restart without lead", sclk_en, 1);
    hold_cs = 1'b0; last = 1'b1;
    @(negedge clk);
    last = 1'b0;
    n = 0;
    for (int i = 0; i < 40 && !(&cs_no); i++) begin n++; @(negedge clk); end
    check(n == 6, "R8 release after hold cleared", n, 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule